// File: doc/BRIEF.md
# Interrupt pending and status controller

This block gathers the level-sensitive interrupt requests of a chip's peripherals and external pins into one place and offers software three 32-bit views over a small register bus. The mask view is writable. A set mask bit blocks its source. The pending view shows every active request, whether or not it is blocked. The status view shows only the requests that are not blocked. The OR of the status view forms one interrupt request line toward the processor.

Sources arrive as levels and pass through a two-flop synchronizer. Pending and status bits follow their sources, so a bit is cleared by servicing the peripheral and not by writing this block.

One source slot, bit 6, is not driven by a peripheral. It is formed from eight key input pins: pressing any key raises it. Software can therefore unmask only this bit, put the core to sleep, and be woken by a keystroke.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, the mask register reads 0x00FFFFFF (every source blocked) and `irq_out` is low.
- R2: A source that is active while its mask bit is 1 shows 1 in the pending view and 0 in the status view.
- R3: A source that is active while its mask bit is 0 shows the same value in the pending view and the status view.
- R4: Writes to the pending address (1) or the status address (2) change no state. The mask and the later reads are the same as if the write had not happened.
- R5: Pending bit 6 is the OR of the eight `key_in` pins. Input `periph_req[6]` has no effect.
- R6: Bits 31..24 read as zero at every address. A mask write stores only bits 23..0.
- R7: `irq_out` is high exactly when at least one bit is set in the status view, which is pending AND NOT mask.
- R8: A change on `periph_req[i]` (for i other than 6) or on `key_in` shows in the pending view after the second rising clock edge that samples it.
- R9: A write to address 0 replaces the mask at the next rising edge, and the new mask reads back from address 0.
- R10: Address 3 reads as zero.
- R11: A pending bit clears on its own, with the same two-edge latency, when its source drops. Nothing has to be written to clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req | input | 24 | Level request per source slot. Bit 6 is unused. |
| key_in | input | 8 | Key pins, active high |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Register select: 0 mask, 1 pending, 2 status, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A corrupted mask register shows up at the ports in the first cycle after the bad write, either in the address-0 readback or in a status word and `irq_out` that disagree with the pending word. A slip in the synchronizer chain shows as pending bits that appear one edge early or late against a two-edge reference. A bad keyboard merge shows as bit 6 that tracks `periph_req[6]` or misses a single pressed key. Every cycle, the bench reads all four addresses and compares `irq_out`, so a bad state is caught within one clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int SRC_W  = 24;
    localparam int REG_W  = 32;
    localparam int KEY_W  = 8;
    localparam int KB_BIT = 6;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK = 2'd0,
        SEL_PEND = 2'd1,
        SEL_STAT = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_W-1:0] pend;
        logic [SRC_W-1:0] stat;
        logic             any;
    } view_t;

    function automatic logic [REG_W-1:0] pad_word(input logic [SRC_W-1:0] v);
        return {{(REG_W-SRC_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] safe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= d_in;
            safe_q <= meta_q;
        end
    end

    assign d_out = safe_q;
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (wr_en)
            mask_q <= wdata;
    end

    AST_MASK_RST_ONES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_q)) else $error("mask not all ones after reset"); // R1
endmodule

// File: rtl/irqc_views.sv
module irqc_views
    import irqc_pkg::*;
(
    input  logic [SRC_W-1:0] src_sync,
    input  logic [KEY_W-1:0] key_sync,
    input  logic [SRC_W-1:0] mask,
    output view_t            view
);
    logic [SRC_W-1:0] pend_w;
    logic             key_any;

    assign key_any = |key_sync;

    for (genvar i = 0; i < SRC_W; i++) begin : g_slot
        if (i == KB_BIT) begin : g_kb
            assign pend_w[i] = key_any;
        end else begin : g_src
            assign pend_w[i] = src_sync[i];
        end
    end

    always_comb begin
        view.pend = pend_w;
        view.stat = pend_w & ~mask;
        view.any  = |view.stat;
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  periph_req,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_out
);
    localparam logic [SRC_W-1:0] KB_ONEHOT = SRC_W'(1) << KB_BIT;
    localparam int               AGE_W     = 2;

    logic [SRC_W-1:0] src_sync;
    logic [KEY_W-1:0] key_sync;
    logic [SRC_W-1:0] mask_q;
    logic             mask_wr;
    view_t            view;
    reg_sel_e         sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign mask_wr = bus_wr && (sel == SEL_MASK);

    irqc_sync #(.WIDTH(SRC_W)) u_sync_src (
        .clk(clk), .rst(rst), .d_in(periph_req), .d_out(src_sync));

    irqc_sync #(.WIDTH(KEY_W)) u_sync_key (
        .clk(clk), .rst(rst), .d_in(key_in), .d_out(key_sync));

    irqc_mask_reg #(.WIDTH(SRC_W)) u_mask (
        .clk(clk), .rst(rst), .wr_en(mask_wr),
        .wdata(bus_wdata[SRC_W-1:0]), .mask_q(mask_q));

    irqc_views u_views (
        .src_sync(src_sync), .key_sync(key_sync), .mask(mask_q), .view(view));

    always_comb begin
        unique case (sel)
            SEL_MASK: bus_rdata = pad_word(mask_q);
            SEL_PEND: bus_rdata = pad_word(view.pend);
            SEL_STAT: bus_rdata = pad_word(view.stat);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = view.any;

    // cycles since reset, saturating; gates the latency checks
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (age_q != AGE_W'(2))
            age_q <= age_q + AGE_W'(1);
    end

    AST_PEND_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q == AGE_W'(2)) |-> ((view.pend & ~KB_ONEHOT) == ($past(periph_req, 2) & ~KB_ONEHOT)))
        else $error("pending does not follow sources"); // R8
    AST_KEY_WAKE: assert property (@(posedge clk) disable iff (rst)
        (age_q == AGE_W'(2)) |-> (view.pend[KB_BIT] == (|$past(key_in, 2))))
        else $error("keyboard bit is not OR of keys"); // R5
    AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        irq_out == (|(src_sync & ~KB_ONEHOT & ~mask_q) || ((|key_sync) && !mask_q[KB_BIT])))
        else $error("irq_out disagrees with unmasked requests"); // R7
    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (sel != SEL_MASK)) |=> $stable(mask_q))
        else $error("read-only write changed mask"); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[REG_W-1:SRC_W] == '0)
        else $error("unused bits not zero"); // R6
endmodule

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] periph_req = '0;
    logic [7:0]  key_in = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [23:0] m_s1, m_s2, m_mask;
    logic [7:0]  k_s1, k_s2;

    irq_pend_ctrl u_irq_pend_ctrl (
        .clk(clk), .rst(rst), .periph_req(periph_req), .key_in(key_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out));

    always #4000 clk = ~clk;

    function automatic logic [31:0] exp_pend();
        logic [23:0] p;
        p = m_s2;
        p[6] = |k_s2;
        return {8'h00, p};
    endfunction

    function automatic logic [31:0] exp_stat();
        return exp_pend() & {8'h00, ~m_mask};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [1:0] a, input logic [31:0] wd,
                       input logic [23:0] rq, input logic [7:0] ky,
                       input string mtag, input string ptag);
        bus_wr = wr; bus_addr = a; bus_wdata = wd; periph_req = rq; key_in = ky;
        @(posedge clk);
        m_s2 = m_s1; k_s2 = k_s1; m_s1 = rq; k_s1 = ky;
        if (wr && a == 2'd0) m_mask = wd[23:0];
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = 2'd0;
        #500;
        check(irq_out == (|exp_stat()), "R7 irq_out", {31'b0, irq_out}, {31'b0, |exp_stat()});
        check(bus_rdata == {8'h00, m_mask}, mtag, bus_rdata, {8'h00, m_mask});
        bus_addr = 2'd1;
        #500;
        check(bus_rdata == exp_pend(), ptag, bus_rdata, exp_pend());
        check(bus_rdata[6] == (|k_s2), "R5 key bit", {31'b0, bus_rdata[6]}, {31'b0, |k_s2});
        check(bus_rdata[31:24] == 8'h00, "R6 upper bits", bus_rdata, exp_pend());
        bus_addr = 2'd2;
        #500;
        check(bus_rdata == exp_stat(), "R2/R3 status", bus_rdata, exp_stat());
        bus_addr = 2'd3;
        #500;
        check(bus_rdata == 32'h0, "R10 reserved", bus_rdata, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_s1 = '0; m_s2 = '0; k_s1 = '0; k_s2 = '0; m_mask = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        bus_addr = 2'd0;
        #500;
        check(bus_rdata == 32'h00FF_FFFF, "R1 mask reset", bus_rdata, 32'h00FF_FFFF);
        check(irq_out == 1'b0, "R1 irq reset", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2: masked source, pending only
        cyc(0, 2'd0, 0, 24'h000008, 8'h00, "R1 mask held", "R8 latency");
        cyc(0, 2'd0, 0, 24'h000008, 8'h00, "R1 mask held", "R2 masked pend");
        // R9: unmask all
        cyc(1, 2'd0, 32'h0, 24'h000008, 8'h00, "R9 mask write", "R3 unmasked");
        cyc(0, 2'd0, 0, 24'h000108, 8'h00, "R9 mask keep", "R8 latency");
        cyc(0, 2'd0, 0, 24'h000108, 8'h00, "R9 mask keep", "R8 latency");
        // R11: sources drop, bits clear by themselves
        cyc(0, 2'd0, 0, 24'h000000, 8'h00, "R9 mask keep", "R11 clear");
        cyc(0, 2'd0, 0, 24'h000000, 8'h00, "R9 mask keep", "R11 clear");
        // R5: periph_req[6] ignored, each key alone raises the bit
        cyc(0, 2'd0, 0, 24'h000040, 8'h00, "R9 mask keep", "R5 ignore slot");
        cyc(0, 2'd0, 0, 24'h000040, 8'h00, "R9 mask keep", "R5 ignore slot");
        for (int k = 0; k < 8; k++) begin
            cyc(0, 2'd0, 0, 24'h0, 8'(1 << k), "R9 mask keep", "R5 one key");
            cyc(0, 2'd0, 0, 24'h0, 8'(1 << k), "R9 mask keep", "R5 one key");
        end
        // R4: writes to read-only addresses
        cyc(0, 2'd0, 0, 24'h800001, 8'h00, "R9 mask keep", "R8 latency");
        cyc(1, 2'd1, 32'hFFFF_FFFF, 24'h800001, 8'h00, "R4 pend write", "R4 pend untouched");
        cyc(1, 2'd2, 32'hFFFF_FFFF, 24'h800001, 8'h00, "R4 stat write", "R4 pend untouched");
        // R6: upper mask bits not stored
        cyc(1, 2'd0, 32'hFFFF_FFFF, 24'h800001, 8'h00, "R6 mask upper", "R8 latency");
        cyc(1, 2'd0, 32'hA500_0001, 24'h800001, 8'h00, "R6 mask upper", "R2 masked pend");

        // random phase
        for (int n = 0; n < 800; n++) begin
            logic [31:0] r;
            logic        wr;
            logic [1:0]  a;
            logic [7:0]  ky;
            r  = $urandom;
            wr = (r[2:0] == 3'd0);
            a  = r[4:3];
            ky = (r[7:5] == 3'd0) ? 8'(1 << r[10:8]) : ((r[7:5] == 3'd1) ? r[23:16] : 8'h00);
            cyc(wr, a, $urandom, 24'($urandom), ky,
                (wr && a != 2'd0) ? "R4 random" : "R9 random", "R8 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule